// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This block keeps the four condition flags of a processor's status word (negative, zero, carry, overflow) and decides, for each instruction presented to it, whether that instruction is allowed to take effect. Every instruction carries a 4-bit condition code. The unit tests that code against the flags it currently holds. A false result turns the instruction into a no-op: no register write and no flag change.

Instructions that set flags load the ALU's N, Z, C and V results on the clock edge that ends their cycle. Such an instruction is either an arithmetic or logic operation with its set-flags request raised, or a compare. A compare never writes a register. A separate status-word write port loads the flags directly. It wins over any ALU update in the same cycle. The decision output is combinational from the stored flags, so an instruction that follows a compare is judged against the new flags.

Top module: `cond_unit`

## Requirements
- R1: After reset every flag is zero, so `statusWord` reads 0.
- R2: With `instValid` high, `execEn` follows the condition code against the stored flags. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R3: Code 14 always executes and code 15 never executes, whatever the flags hold.
- R4: With `instValid` low, `execEn`, `regWrEn` and any flag update are suppressed.
- R5: An executed instruction with `setFlags` high loads {aluN, aluZ, aluC, aluV} into the flags at the next rising edge.
- R6: An executed non-compare instruction with `setFlags` low leaves the flags unchanged.
- R7: An executed compare (`isCompare` high) loads the ALU flags whatever `setFlags` is, and holds `regWrEn` low.
- R8: An instruction whose predicate is false raises neither `regWrEn` nor any flag change.
- R9: `statusWrEn` loads bits 31..28 of `statusWrData` as N, Z, C, V at the next edge, taking priority over an ALU update in the same cycle.
- R10: `statusWord` carries N, Z, C, V on bits 31, 30, 29, 28 and zero on every other bit.
- R11: `execEn` depends on the flags stored at the time, so a predicated instruction in the cycle after a compare sees the compare's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is present this cycle |
| condCode | input | 4 | Condition code of the instruction |
| setFlags | input | 1 | Arithmetic or logic instruction requests a flag update |
| isCompare | input | 1 | Instruction is a compare: flags only, no register write |
| aluN | input | 1 | ALU negative result |
| aluZ | input | 1 | ALU zero result |
| aluC | input | 1 | ALU carry result |
| aluV | input | 1 | ALU overflow result |
| statusWrEn | input | 1 | Direct status-word write |
| statusWrData | input | 32 | Status word to write; bits 31..28 used |
| execEn | output | 1 | Instruction executes |
| regWrEn | output | 1 | Executed instruction may write its destination register |
| statusWord | output | 32 | Current status word with the flags in bits 31..28 |

## Verification
The assertions assume that `setFlags`, `isCompare` and the ALU flag inputs are known whenever `instValid` is high. They also assume that `statusWrData` is known whenever `statusWrEn` is high. The bench meets this by driving every input to a defined value from reset onward and changing inputs only just after a rising edge. It sweeps all sixteen flag combinations against all sixteen condition codes, loading each combination through the status-write port. It then runs short sequences for compare-then-branch timing, suppressed updates, and write-port priority.

// File: rtl/cond_pkg.sv
package cond_pkg;
  typedef enum logic [3:0] {
    CondEq = 4'd0,  CondNe = 4'd1,  CondCs = 4'd2,  CondCc = 4'd3,
    CondMi = 4'd4,  CondPl = 4'd5,  CondVs = 4'd6,  CondVc = 4'd7,
    CondHi = 4'd8,  CondLs = 4'd9,  CondGe = 4'd10, CondLt = 4'd11,
    CondGt = 4'd12, CondLe = 4'd13, CondAl = 4'd14, CondNv = 4'd15
  } condCodeT;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flagsT;

  typedef struct packed {
    logic execute;
    logic regWrite;
    logic flagLoad;
  } strobeT;
endpackage

// File: rtl/cond_ctrl.sv
module cond_ctrl
  import cond_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [3:0] condCode,
  input  logic       setFlags,
  input  logic       isCompare,
  input  flagsT      flags,
  output strobeT     strobe
);
  condCodeT code;
  logic     predTrue;

  assign code = condCodeT'(condCode);

  always_comb begin
    unique case (code)
      CondEq: predTrue = flags.z;
      CondNe: predTrue = !flags.z;
      CondCs: predTrue = flags.c;
      CondCc: predTrue = !flags.c;
      CondMi: predTrue = flags.n;
      CondPl: predTrue = !flags.n;
      CondVs: predTrue = flags.v;
      CondVc: predTrue = !flags.v;
      CondHi: predTrue = flags.c && !flags.z;
      CondLs: predTrue = !flags.c || flags.z;
      CondGe: predTrue = (flags.n == flags.v);
      CondLt: predTrue = (flags.n != flags.v);
      CondGt: predTrue = !flags.z && (flags.n == flags.v);
      CondLe: predTrue = flags.z || (flags.n != flags.v);
      CondAl: predTrue = 1'b1;
      CondNv: predTrue = 1'b0;
      default: predTrue = 1'b0;
    endcase
  end

  always_comb begin
    strobe.execute  = instValid && predTrue;
    strobe.regWrite = strobe.execute && !isCompare;
    strobe.flagLoad = strobe.execute && (setFlags || isCompare);
  end

  // R3
  always_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && condCode == 4'd15) |-> !strobe.execute);
  // R3
  always_true_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && condCode == 4'd14) |-> strobe.execute);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (!strobe.execute && !strobe.regWrite && !strobe.flagLoad));
  // R7
  compare_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCompare |-> !strobe.regWrite);
endmodule

// File: rtl/cond_flags_dp.sv
module cond_flags_dp
  import cond_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int FLAG_TOP = 31
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  flagsT               aluFlags,
  input  logic                statusWrEn,
  input  logic [STATUS_W-1:0] statusWrData,
  output flagsT               flags,
  output logic [STATUS_W-1:0] statusWord
);
  localparam int FLAG_BOT = FLAG_TOP - 3;

  flagsT flagsQ;

  always_ff @(posedge clk) begin
    if (!rstN)
      flagsQ <= '0;
    else if (statusWrEn)
      flagsQ <= flagsT'(statusWrData[FLAG_TOP:FLAG_BOT]);
    else if (strobe.flagLoad)
      flagsQ <= aluFlags;
  end

  assign flags = flagsQ;

  always_comb begin
    statusWord = '0;
    statusWord[FLAG_TOP:FLAG_BOT] = flagsQ;
  end

  // R9
  status_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWrEn |=> (statusWord[FLAG_TOP:FLAG_BOT] == $past(statusWrData[FLAG_TOP:FLAG_BOT])));
  // R5
  alu_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWrEn && strobe.flagLoad) |=> (statusWord[FLAG_TOP:FLAG_BOT] == $past(aluFlags)));
  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWrEn && !strobe.flagLoad) |=> $stable(statusWord));
endmodule

// File: rtl/cond_unit.sv
module cond_unit
  import cond_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int FLAG_TOP = 31
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [3:0]          condCode,
  input  logic                setFlags,
  input  logic                isCompare,
  input  logic                aluN,
  input  logic                aluZ,
  input  logic                aluC,
  input  logic                aluV,
  input  logic                statusWrEn,
  input  logic [STATUS_W-1:0] statusWrData,
  output logic                execEn,
  output logic                regWrEn,
  output logic [STATUS_W-1:0] statusWord
);
  strobeT strobe;
  flagsT  flags;
  flagsT  aluFlags;

  assign aluFlags = '{n: aluN, z: aluZ, c: aluC, v: aluV};

  cond_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .condCode(condCode),
    .setFlags(setFlags), .isCompare(isCompare), .flags(flags), .strobe(strobe)
  );

  cond_flags_dp #(.STATUS_W(STATUS_W), .FLAG_TOP(FLAG_TOP)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .aluFlags(aluFlags),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .flags(flags), .statusWord(statusWord)
  );

  assign execEn  = strobe.execute;
  assign regWrEn = strobe.regWrite;
endmodule

// File: tb/tb_cond_unit.sv
module tb_cond_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  condCode = 4'd0;
  logic        setFlags = 1'b0;
  logic        isCompare = 1'b0;
  logic        aluN = 1'b0, aluZ = 1'b0, aluC = 1'b0, aluV = 1'b0;
  logic        statusWrEn = 1'b0;
  logic [31:0] statusWrData = '0;
  logic        execEn, regWrEn;
  logic [31:0] statusWord;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_unit dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .condCode(condCode),
    .setFlags(setFlags), .isCompare(isCompare),
    .aluN(aluN), .aluZ(aluZ), .aluC(aluC), .aluV(aluV),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .execEn(execEn), .regWrEn(regWrEn), .statusWord(statusWord)
  );

  // Predicate from the requirement table: pairs share a base test, odd codes invert it.
  function automatic logic expPred(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code >> 1)
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    return base ^ code[0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic writeFlags(input logic [3:0] f);
    statusWrEn = 1'b1;
    statusWrData = {f, 28'h0};
    tick();
    statusWrEn = 1'b0;
    statusWrData = '0;
  endtask

  task automatic setAlu(input logic [3:0] f);
    {aluN, aluZ, aluC, aluV} = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    check("R1", statusWord, 32'h0);
    rstN = 1'b1;
    tick();
    check("R1", statusWord, 32'h0);

    // R2 R3: exhaustive sweep of flags against codes
    for (int f = 0; f < 16; f++) begin
      writeFlags(4'(f));
      for (int k = 0; k < 16; k++) begin
        instValid = 1'b1;
        condCode = 4'(k);
        #1;
        if (k >= 14) check("R3", {31'h0, execEn}, {31'h0, (k == 14)});
        else         check("R2", {31'h0, execEn}, {31'h0, expPred(4'(k), 4'(f))});
        check("R2", {31'h0, regWrEn}, {31'h0, execEn});
        instValid = 1'b0;
        #1;
        // R4: no valid instruction, nothing executes
        check("R4", {30'h0, execEn, regWrEn}, 32'h0);
      end
    end

    // R10: only bits 31..28 captured and shown
    statusWrEn = 1'b1; statusWrData = 32'hA5A5_5A5A;
    tick();
    statusWrEn = 1'b0; statusWrData = '0;
    check("R10", statusWord, 32'hA000_0000);

    // R4: invalid instruction with flag request loads nothing
    writeFlags(4'h0);
    instValid = 1'b0; condCode = 4'd14; setFlags = 1'b1; isCompare = 1'b1; setAlu(4'hF);
    tick();
    check("R4", statusWord, 32'h0);
    setFlags = 1'b0; isCompare = 1'b0;

    // R5: executed flag-setting instruction loads ALU flags next edge
    instValid = 1'b1; condCode = 4'd14; setFlags = 1'b1; setAlu(4'h9);
    #1;
    check("R5", statusWord, 32'h0);
    tick();
    check("R5", statusWord, 32'h9000_0000);

    // R6: set-flags low leaves flags unchanged
    setFlags = 1'b0; setAlu(4'h6);
    #1;
    check("R6", {31'h0, regWrEn}, 32'h1);
    tick();
    check("R6", statusWord, 32'h9000_0000);

    // R7: compare loads flags without setFlags, no register write
    isCompare = 1'b1; setAlu(4'h4);
    #1;
    check("R7", {30'h0, execEn, regWrEn}, 32'h2);
    tick();
    check("R7", statusWord, 32'h4000_0000);

    // R11: before the compare's edge, EQ is judged on old flags; after it, on new
    writeFlags(4'h0);
    isCompare = 1'b1; setFlags = 1'b0; condCode = 4'd14; setAlu(4'h4);
    #1;
    condCode = 4'd0;
    #1;
    check("R11", {31'h0, execEn}, 32'h0);
    condCode = 4'd14;
    tick();
    isCompare = 1'b0; condCode = 4'd0;
    #1;
    check("R11", {31'h0, execEn}, 32'h1);
    condCode = 4'd1;
    #1;
    check("R11", {31'h0, execEn}, 32'h0);

    // R8: false predicate: no write, no flag change (Z set, NE fails)
    setFlags = 1'b1; isCompare = 1'b0; setAlu(4'hB);
    #1;
    check("R8", {31'h0, regWrEn}, 32'h0);
    tick();
    check("R8", statusWord, 32'h4000_0000);
    isCompare = 1'b1; condCode = 4'd15;
    tick();
    check("R8", statusWord, 32'h4000_0000);

    // R9: status write beats an ALU update in the same cycle
    condCode = 4'd14; isCompare = 1'b1; setAlu(4'hF);
    statusWrEn = 1'b1; statusWrData = 32'h2000_0000;
    tick();
    statusWrEn = 1'b0; statusWrData = '0;
    check("R9", statusWord, 32'h2000_0000);
    instValid = 1'b0; isCompare = 1'b0; setFlags = 1'b0;
    tick();
    check("R9", statusWord, 32'h2000_0000);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule